// File: doc/BRIEF.md
# Bridge Interrupt Control/Status Register

This block is the interrupt control and status word of a host bus bridge. It watches one interrupt line from the local side and drives one active-low interrupt towards the host. Software reaches the block through a single 32-bit register, written with a one-cycle write strobe and read back at any time. Through that register software can enable the local source, choose which input level counts as active, and choose between level and edge triggering. It can also read the current interrupt status, enable the host output, and, in edge mode, clear a latched event by writing a one.

In level mode the status bit follows the polarity-corrected input, gated by the local enable, one clock after the input. In edge mode a rising edge of the corrected input sets a sticky status bit, which stays set until software clears it. If an edge arrives in the same cycle as a clear, the edge wins. Edge mode is only valid with the active-high polarity selected. With active-low polarity, edge mode never latches. A mode-keep bit resets to 1. It is stored and read back, and software is expected to leave it at 1. All bits without a function read as zero.

Top module: `bridge_irq_csr`

## Requirements
- R1: After reset the register reads 0x0000_1001: local enable (bit 0) is 1, the mode-keep bit (bit 12) is 1, and all other bits are 0. The host output `host_irq_n` is high.
- R2: Only bits 0, 1, 2, 6, 8 and 12 can read as 1. The clear bit (bit 10) and every undefined bit always read 0.
- R3: In level mode (bit 8 = 0), the status bit (bit 2) equals the corrected input one clock after the input changes. The input is taken as is when bit 1 = 1 and inverted when bit 1 = 0.
- R4: When the local enable (bit 0) is 0, the status bit stays 0 whatever the input does.
- R5: In edge mode (bit 8 = 1, bit 1 = 1), a 0-to-1 change of the input sets the status bit one clock later. The bit stays set after the input returns to 0.
- R6: In edge mode, a write with bit 10 = 1 clears the latched status at that clock edge. A new rising edge sampled at the same edge keeps the status at 1.
- R7: In level mode, a write with bit 10 = 1 has no effect on the status bit.
- R8: In edge mode with bit 1 = 0, input changes never set the status bit.
- R9: `host_irq_n` is low exactly when the status bit and the host enable (bit 6) are both 1.
- R10: The mode-keep bit (bit 12) is writable and reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr | input | 1 | Write strobe, one cycle per write |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current register contents |
| irq_in | input | 1 | Local interrupt line |
| host_irq_n | output | 1 | Host interrupt, active low |

## Verification
The level path is driven with the input held high and held low under both polarities. This separates polarity inversion from plain pass-through, and shows the local and host enables masking the status and the output independently. The edge path uses a single pulse followed by a return to low, which separates a sticky latch from a level follower. It also uses a clear with the input held high, which must not re-latch because there is no new edge. Finally, a clear issued in the same cycle as a fresh edge checks that the edge takes priority. Edge mode with active-low polarity and a toggling input shows that the invalid configuration never latches. A clear written in level mode shows that the clear is ignored there.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
    localparam int unsigned CSR_W     = 32;
    localparam int unsigned B_LOC_EN  = 0;
    localparam int unsigned B_POL     = 1;
    localparam int unsigned B_STATUS  = 2;
    localparam int unsigned B_HOST_EN = 6;
    localparam int unsigned B_EDGE    = 8;
    localparam int unsigned B_CLEAR   = 10;
    localparam int unsigned B_KEEP    = 12;

    typedef struct packed {
        logic loc_en;
        logic pol_high;
        logic host_en;
        logic edge_mode;
        logic mode_keep;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{loc_en: 1'b1, pol_high: 1'b0, host_en: 1'b0,
                                     edge_mode: 1'b0, mode_keep: 1'b1};

    typedef struct packed {
        logic prev;
        logic lvl;
        logic latch;
    } trig_t;
endpackage

// File: rtl/irq_ctrl_fields.sv
module irq_ctrl_fields
    import irq_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CSR_W-1:0]   wdata,
    output ctrl_t              ctrl,
    output logic               clr_req
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.loc_en    = wdata[B_LOC_EN];
            ctrl_d.pol_high  = wdata[B_POL];
            ctrl_d.host_en   = wdata[B_HOST_EN];
            ctrl_d.edge_mode = wdata[B_EDGE];
            ctrl_d.mode_keep = wdata[B_KEEP];
        end
        clr_req = wr_en & wdata[B_CLEAR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    p_keep_written_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q.mode_keep == $past(wdata[B_KEEP])));
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
    import irq_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_raw,
    input  logic loc_en,
    input  logic pol_high,
    input  logic edge_mode,
    input  logic clr_req,
    output logic status
);
    trig_t st_d, st_q;
    logic  corr;
    logic  edge_hit;
    logic  clr_ok;

    always_comb begin
        corr     = pol_high ? irq_raw : ~irq_raw;
        edge_hit = edge_mode & pol_high & loc_en & corr & ~st_q.prev;
        clr_ok   = clr_req & edge_mode;
        st_d.prev  = corr;
        st_d.lvl   = loc_en & corr;
        st_d.latch = edge_mode ? (edge_hit | (st_q.latch & ~clr_ok)) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = edge_mode ? st_q.latch : st_q.lvl;

    p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && st_q.latch && !clr_req) |=> st_q.latch);
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && clr_req && !edge_hit) |=> !st_q.latch);
    p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> st_q.latch);
    p_lowpol_no_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_high && !st_q.latch) |=> !st_q.latch);
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_en |=> !st_q.lvl);
endmodule

// File: rtl/bridge_irq_csr.sv
module bridge_irq_csr
    import irq_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      csr_rdata,
    input  logic             irq_in,
    output logic             host_irq_n
);
    ctrl_t ctrl;
    logic  clr_req;
    logic  status;

    irq_ctrl_fields u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_wr),
        .wdata   (csr_wdata),
        .ctrl    (ctrl),
        .clr_req (clr_req)
    );

    irq_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_raw   (irq_in),
        .loc_en    (ctrl.loc_en),
        .pol_high  (ctrl.pol_high),
        .edge_mode (ctrl.edge_mode),
        .clr_req   (clr_req),
        .status    (status)
    );

    always_comb begin
        csr_rdata            = '0;
        csr_rdata[B_LOC_EN]  = ctrl.loc_en;
        csr_rdata[B_POL]     = ctrl.pol_high;
        csr_rdata[B_STATUS]  = status;
        csr_rdata[B_HOST_EN] = ctrl.host_en;
        csr_rdata[B_EDGE]    = ctrl.edge_mode;
        csr_rdata[B_KEEP]    = ctrl.mode_keep;
        host_irq_n           = ~(status & ctrl.host_en);
    end

    p_host_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.host_en |-> host_irq_n);
endmodule

// File: tb/tb_bridge_irq_csr.sv
module tb_bridge_irq_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq_in = 1'b1;
    logic        host_irq_n;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    bridge_irq_csr dut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .irq_in(irq_in), .host_irq_n(host_irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        csr_wr = 1'b1;
        csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
        csr_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R1 reset word", csr_rdata, 32'h0000_1001);
        chk("R1 reset host", {31'd0, host_irq_n}, 32'd1);
    endtask

    task automatic t_reserved();
        wr(32'hFFFF_FFFF);
        step();
        chk("R2 undefined bits zero", csr_rdata & ~32'h0000_1147, 32'd0);
        chk("R2 clear bit zero", {31'd0, csr_rdata[10]}, 32'd0);
        wr(32'h0000_1001);
        step(); step();
    endtask

    task automatic t_level_high();
        irq_in = 1'b0;
        wr(32'h0000_1043);
        step();
        chk("R3 high pol idle", {31'd0, csr_rdata[2]}, 32'd0);
        chk("R9 idle host", {31'd0, host_irq_n}, 32'd1);
        irq_in = 1'b1; step();
        chk("R3 high pol active", {31'd0, csr_rdata[2]}, 32'd1);
        chk("R9 host asserted", {31'd0, host_irq_n}, 32'd0);
        irq_in = 1'b0; step();
        chk("R3 high pol follows low", {31'd0, csr_rdata[2]}, 32'd0);
    endtask

    task automatic t_level_low();
        wr(32'h0000_1041);
        irq_in = 1'b0; step();
        chk("R3 low pol active", {31'd0, csr_rdata[2]}, 32'd1);
        irq_in = 1'b1; step();
        chk("R3 low pol idle", {31'd0, csr_rdata[2]}, 32'd0);
    endtask

    task automatic t_enables();
        wr(32'h0000_1042);
        irq_in = 1'b1; step();
        chk("R4 local disabled status", {31'd0, csr_rdata[2]}, 32'd0);
        chk("R4 local disabled host", {31'd0, host_irq_n}, 32'd1);
        wr(32'h0000_1003);
        step();
        chk("R9 host off status", {31'd0, csr_rdata[2]}, 32'd1);
        chk("R9 host off output", {31'd0, host_irq_n}, 32'd1);
    endtask

    task automatic t_level_clear();
        wr(32'h0000_1043);
        step();
        wr(32'h0000_1443);
        chk("R7 clear ignored level", {31'd0, csr_rdata[2]}, 32'd1);
        step();
        chk("R7 still active", {31'd0, csr_rdata[2]}, 32'd1);
    endtask

    task automatic t_edge();
        irq_in = 1'b0; step();
        wr(32'h0000_1143);
        step();
        chk("R5 edge idle", {31'd0, csr_rdata[2]}, 32'd0);
        irq_in = 1'b1; step();
        chk("R5 edge latched", {31'd0, csr_rdata[2]}, 32'd1);
        irq_in = 1'b0; step(); step();
        chk("R5 held after input low", {31'd0, csr_rdata[2]}, 32'd1);
        chk("R9 edge host", {31'd0, host_irq_n}, 32'd0);
        wr(32'h0000_1543);
        chk("R6 clear drops", {31'd0, csr_rdata[2]}, 32'd0);
        irq_in = 1'b1; step();
        irq_in = 1'b0; step();
        irq_in = 1'b1;
        wr(32'h0000_1543);
        chk("R6 edge beats clear", {31'd0, csr_rdata[2]}, 32'd1);
        step();
        wr(32'h0000_1543);
        chk("R6 clear with steady high", {31'd0, csr_rdata[2]}, 32'd0);
        step();
        chk("R6 no relatch without edge", {31'd0, csr_rdata[2]}, 32'd0);
    endtask

    task automatic t_edge_lowpol();
        irq_in = 1'b0;
        wr(32'h0000_1141);
        for (int i = 0; i < 6; i++) begin
            irq_in = ~irq_in; step();
            chk("R8 low pol edge never latches", {31'd0, csr_rdata[2]}, 32'd0);
        end
    endtask

    task automatic t_keep();
        irq_in = 1'b1;
        wr(32'h0000_0001);
        chk("R10 keep cleared", {31'd0, csr_rdata[12]}, 32'd0);
        wr(32'h0000_1001);
        chk("R10 keep restored", {31'd0, csr_rdata[12]}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_reserved();
        t_level_high();
        t_level_low();
        t_enables();
        t_level_clear();
        t_edge();
        t_edge_lowpol();
        t_keep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule